// File: doc/BRIEF.md
# Top-of-Memory Firmware Decode Router

This block sits on the memory-read request path and sends each request to one of two destinations: the firmware flash interface or the main memory controller. The highest 512 KB of the 32-bit space is split into eight windows of 64 KB each. Each window has its own enable bit in a small bitmap, and software can rewrite that bitmap through a plain write port. A request whose address falls inside an enabled window goes to firmware. Every other request goes to memory. All enable bits come out of reset set, so the first instruction fetch after reset (at FFFF_FFF0h) always reaches firmware storage.

The request input and both outputs are valid/ready streams. The router holds one request at a time in a single staging register, together with the destination decided when the request was accepted. A staged request is offered on exactly one output. It keeps its valid and address unchanged until that output's ready is high at a clock edge. The input's ready is high when the stage is empty, or when the chosen output takes the staged request in the same cycle. Back-pressure on the chosen output therefore stalls the input. Back-pressure on the other output has no effect. With both readies held high, one request passes per cycle with one cycle of latency.

A write to the bitmap takes effect on the clock edge where it is written. A request accepted on that same edge is decoded with the bitmap as it was before the write.

Top module: `fwdec_router`

## Requirements
- R1: After reset, fw_valid and mem_valid are 0, req_ready is 1, and all eight enable bits are 1, so every window routes to firmware.
- R2: With the reset bitmap, a request at FFFF_FFF0h appears on the firmware output and not on the memory output.
- R3: A request in a window whose enable bit is 1 appears on the firmware output with its address unchanged, and mem_valid stays 0.
- R4: A request in a window whose enable bit is 0 appears on the memory output with its address unchanged.
- R5: A request below FFF8_0000h goes to the memory output whatever the bitmap holds.
- R6: Bit n of cfg_wdata controls the window from FFF8_0000h + n*10000h to FFF8_FFFFh + n*10000h. Bit 0 covers FFF8_0000h and bit 7 covers FFFF_0000h–FFFF_FFFFh.
- R7: fw_valid and mem_valid are never both 1.
- R8: While a staged request waits with its output's ready low, that output keeps valid high with a stable address, and req_ready is 0.
- R9: A request accepted at a clock edge is offered on an output from that edge on. With readies high, back-to-back requests are accepted one per cycle.
- R10: A write with cfg_we high changes routing for requests accepted after that edge. A request accepted on the write edge uses the previous bitmap.
- R11: A request already staged keeps its destination if the bitmap is rewritten while it waits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Incoming read request valid |
| req_ready | output | 1 | Router can accept the request |
| req_addr | input | 32 | Incoming request address |
| fw_valid | output | 1 | Request offered to firmware interface |
| fw_ready | input | 1 | Firmware interface accepts |
| fw_addr | output | 32 | Address toward firmware interface |
| mem_valid | output | 1 | Request offered to memory controller |
| mem_ready | input | 1 | Memory controller accepts |
| mem_addr | output | 32 | Address toward memory controller |
| cfg_we | input | 1 | Enable bitmap write strobe |
| cfg_wdata | input | 8 | New enable bitmap, bit n = window n |

## Verification
The assertions check the stream rules on every cycle:
- the two outputs are never offered together;
- a stalled output holds its address and blocks the input;
- an accepted address shows up on an output one edge later;
- anything below the firmware region lands on memory.

Which window maps to which bit, the reset default of the bitmap, and the exact edge where a bitmap write takes effect depend on sequences the bench drives itself. These are shown only by its scenarios: the walking single-bit bitmaps, the write coinciding with an accept, and a rewrite during a stall.

// File: rtl/fwdec_pkg.sv
package fwdec_pkg;
  typedef enum logic {
    DEST_MEM = 1'b0,
    DEST_FW  = 1'b1
  } fwdec_dest_e;
endpackage

// File: rtl/fwdec_enable_reg.sv
module fwdec_enable_reg #(
  parameter int NUM_WIN = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we,
  input  logic [NUM_WIN-1:0] wdata,
  output logic [NUM_WIN-1:0] en
);
  // reset default: every window claimed for firmware
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en <= '1;
    else if (we) en <= wdata;
  end
endmodule

// File: rtl/fwdec_window_match.sv
module fwdec_window_match #(
  parameter int ADDR_W   = 32,
  parameter int NUM_WIN  = 8,
  parameter int WIN_BITS = 16
) (
  input  logic [ADDR_W-1:0]  addr,
  input  logic [NUM_WIN-1:0] en,
  output logic               hit
);
  localparam int IDX_W = $clog2(NUM_WIN);
  localparam int TOP_W = ADDR_W - WIN_BITS - IDX_W;

  logic               in_region;
  logic [IDX_W-1:0]   idx;
  logic [NUM_WIN-1:0] win_sel;

  assign in_region = &addr[ADDR_W-1 -: TOP_W];
  assign idx       = addr[WIN_BITS +: IDX_W];

  for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
    assign win_sel[g] = in_region && (idx == IDX_W'(g));
  end

  assign hit = |(win_sel & en);
endmodule

// File: rtl/fwdec_route_stage.sv
module fwdec_route_stage
  import fwdec_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic              in_fw,
  output logic              fw_valid,
  input  logic              fw_ready,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic [ADDR_W-1:0] out_addr
);
  logic              hold_v;
  fwdec_dest_e       hold_dest;
  logic [ADDR_W-1:0] hold_addr;
  logic              sel_ready;
  logic              accept;

  assign sel_ready = (hold_dest == DEST_FW) ? fw_ready : mem_ready;
  assign in_ready  = !hold_v || sel_ready;
  assign accept    = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_v    <= 1'b0;
      hold_dest <= DEST_MEM;
      hold_addr <= '0;
    end else if (accept) begin
      hold_v    <= 1'b1;
      hold_dest <= in_fw ? DEST_FW : DEST_MEM;
      hold_addr <= in_addr;
    end else if (sel_ready) begin
      hold_v <= 1'b0;
    end
  end

  assign fw_valid  = hold_v && (hold_dest == DEST_FW);
  assign mem_valid = hold_v && (hold_dest == DEST_MEM);
  assign out_addr  = hold_addr;
endmodule

// File: rtl/fwdec_router.sv
module fwdec_router #(
  parameter int ADDR_W   = 32,
  parameter int NUM_WIN  = 8,
  parameter int WIN_BITS = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [ADDR_W-1:0]  req_addr,
  output logic               fw_valid,
  input  logic               fw_ready,
  output logic [ADDR_W-1:0]  fw_addr,
  output logic               mem_valid,
  input  logic               mem_ready,
  output logic [ADDR_W-1:0]  mem_addr,
  input  logic               cfg_we,
  input  logic [NUM_WIN-1:0] cfg_wdata
);
  logic [NUM_WIN-1:0] en;
  logic               hit;
  logic [ADDR_W-1:0]  stage_addr;

  fwdec_enable_reg #(.NUM_WIN(NUM_WIN)) enable_i (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .wdata(cfg_wdata), .en(en)
  );

  fwdec_window_match #(.ADDR_W(ADDR_W), .NUM_WIN(NUM_WIN), .WIN_BITS(WIN_BITS)) match_i (
    .addr(req_addr), .en(en), .hit(hit)
  );

  fwdec_route_stage #(.ADDR_W(ADDR_W)) stage_i (
    .clk(clk), .rst_n(rst_n),
    .in_valid(req_valid), .in_ready(req_ready), .in_addr(req_addr), .in_fw(hit),
    .fw_valid(fw_valid), .fw_ready(fw_ready),
    .mem_valid(mem_valid), .mem_ready(mem_ready),
    .out_addr(stage_addr)
  );

  assign fw_addr  = stage_addr;
  assign mem_addr = stage_addr;
endmodule

// File: rtl/fwdec_router_chk.sv
module fwdec_router_chk #(
  parameter int ADDR_W   = 32,
  parameter int NUM_WIN  = 8,
  parameter int WIN_BITS = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [ADDR_W-1:0] req_addr,
  input logic              fw_valid,
  input logic              fw_ready,
  input logic [ADDR_W-1:0] fw_addr,
  input logic              mem_valid,
  input logic              mem_ready,
  input logic [ADDR_W-1:0] mem_addr
);
  localparam logic [ADDR_W-1:0] REGION_BASE =
    ~((ADDR_W'(NUM_WIN) << WIN_BITS) - ADDR_W'(1));

  // R7
  one_dest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(fw_valid && mem_valid));

  // R8
  fw_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fw_valid && !fw_ready) |=> (fw_valid && $stable(fw_addr)));

  // R8
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr)));

  // R8
  stall_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((fw_valid && !fw_ready) || (mem_valid && !mem_ready)) |-> !req_ready);

  // R9
  pass_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=>
      ((fw_valid && fw_addr == $past(req_addr)) ||
       (mem_valid && mem_addr == $past(req_addr))));

  // R5
  low_to_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_addr < REGION_BASE) |=> mem_valid);
endmodule

bind fwdec_router fwdec_router_chk #(
  .ADDR_W(ADDR_W), .NUM_WIN(NUM_WIN), .WIN_BITS(WIN_BITS)
) chk_i (
  .clk(clk), .rst_n(rst_n),
  .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
  .fw_valid(fw_valid), .fw_ready(fw_ready), .fw_addr(fw_addr),
  .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_addr(mem_addr)
);

// File: tb/fwdec_router_tb_top.sv
`timescale 1ns/1ps
module fwdec_router_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic        fw_valid, mem_valid;
  logic        fw_ready = 1'b1;
  logic        mem_ready = 1'b1;
  logic [31:0] fw_addr, mem_addr;
  logic        cfg_we = 1'b0;
  logic [7:0]  cfg_wdata = '0;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  localparam logic [31:0] BASE = 32'hFFF8_0000;

  always #5 clk = ~clk;

  fwdec_router dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .fw_valid(fw_valid), .fw_ready(fw_ready), .fw_addr(fw_addr),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_addr(mem_addr),
    .cfg_we(cfg_we), .cfg_wdata(cfg_wdata)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // verify the staged request at a negedge: destination and address
  task automatic check_out(input string req, input logic [31:0] addr, input bit to_fw);
    check(req, "fw_valid", 32'(fw_valid), 32'(to_fw));
    check(req, "mem_valid", 32'(mem_valid), 32'(!to_fw));
    check(req, "addr", to_fw ? fw_addr : mem_addr, addr);
  endtask

  // one request with both readies high; checked one cycle later
  task automatic send(input string req, input logic [31:0] addr, input bit to_fw);
    @(negedge clk);
    req_valid = 1'b1;
    req_addr  = addr;
    @(posedge clk);
    #1 req_valid = 1'b0;
    @(negedge clk);
    check_out(req, addr, to_fw);
  endtask

  task automatic write_en(input logic [7:0] val);
    @(negedge clk);
    cfg_we = 1'b1;
    cfg_wdata = val;
    @(posedge clk);
    #1 cfg_we = 1'b0;
  endtask

  task automatic t_reset;
    @(negedge clk);
    check("R1", "fw_valid", 32'(fw_valid), 0);
    check("R1", "mem_valid", 32'(mem_valid), 0);
    check("R1", "req_ready", 32'(req_ready), 1);
  endtask

  task automatic t_reset_vector;
    send("R2", 32'hFFFF_FFF0, 1'b1);
    // R1: reset bitmap claims every window
    for (int n = 0; n < 8; n++) send("R1", BASE + 32'(n) * 32'h1_0000 + 32'h1234, 1'b1);
  endtask

  task automatic t_outside;
    send("R5", 32'h0000_0000, 1'b0);
    send("R5", 32'hFFF7_FFFF, 1'b0);
    send("R5", 32'h8000_0000, 1'b0);
    send("R6", 32'hFFF8_0000, 1'b1);
    send("R6", 32'hFFFF_FFFF, 1'b1);
  endtask

  task automatic t_disable_top;
    write_en(8'h7F);
    send("R4", 32'hFFFF_FFF0, 1'b0);
    send("R3", 32'hFFFE_FFFF, 1'b1);
  endtask

  task automatic t_walking;
    for (int n = 0; n < 8; n++) begin
      write_en(8'(1 << n));
      for (int m = 0; m < 8; m++)
        send("R6", BASE + 32'(m) * 32'h1_0000 + 32'h0040, m == n);
    end
    write_en(8'h00);
    send("R5", 32'h0001_0000, 1'b0);
  endtask

  task automatic t_write_same_edge;
    write_en(8'hFF);
    @(negedge clk);
    cfg_we = 1'b1;
    cfg_wdata = 8'h00;
    req_valid = 1'b1;
    req_addr = 32'hFFFF_0000;
    @(posedge clk);
    #1 begin cfg_we = 1'b0; req_valid = 1'b0; end
    @(negedge clk);
    check_out("R10", 32'hFFFF_0000, 1'b1);
    send("R10", 32'hFFFF_0000, 1'b0);
  endtask

  task automatic t_backpressure;
    write_en(8'hFF);
    @(negedge clk);
    fw_ready = 1'b0;
    req_valid = 1'b1;
    req_addr = 32'hFFFF_FFF0;
    @(posedge clk);
    #1 req_addr = 32'h0000_1000;   // next request waits at the input
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check_out("R8", 32'hFFFF_FFF0, 1'b1);
      check("R8", "req_ready", 32'(req_ready), 0);
    end
    fw_ready = 1'b1;
    @(posedge clk);
    #1 req_valid = 1'b0;
    @(negedge clk);
    check_out("R8", 32'h0000_1000, 1'b0);
    @(negedge clk);
    check("R8", "idle fw_valid", 32'(fw_valid), 0);
    check("R8", "idle mem_valid", 32'(mem_valid), 0);
  endtask

  task automatic t_rewrite_while_held;
    @(negedge clk);
    fw_ready = 1'b0;
    req_valid = 1'b1;
    req_addr = 32'hFFFC_0010;
    @(posedge clk);
    #1 begin req_valid = 1'b0; cfg_we = 1'b1; cfg_wdata = 8'h00; end
    @(posedge clk);
    #1 cfg_we = 1'b0;
    @(negedge clk);
    check_out("R11", 32'hFFFC_0010, 1'b1);
    fw_ready = 1'b1;
    @(negedge clk);
    check("R11", "drained fw_valid", 32'(fw_valid), 0);
    send("R11", 32'hFFFC_0010, 1'b0);
  endtask

  task automatic t_back_to_back;
    logic [31:0] a [4];
    a[0] = 32'hFFFF_FFF0; a[1] = 32'h0000_2000; a[2] = 32'hFFF9_0000; a[3] = 32'h1234_5678;
    write_en(8'h80);
    @(negedge clk);
    req_valid = 1'b1;
    req_addr = a[0];
    for (int k = 1; k < 4; k++) begin
      @(negedge clk);
      check("R9", "req_ready", 32'(req_ready), 1);
      check_out("R9", a[k-1], k == 1);
      req_addr = a[k];
    end
    @(negedge clk);
    req_valid = 1'b0;
    check_out("R9", a[3], 1'b0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_reset_vector();
    t_outside();
    t_disable_top();
    t_walking();
    t_write_same_edge();
    t_backpressure();
    t_rewrite_while_held();
    t_back_to_back();
    repeat (2) @(negedge clk);
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 20000 && !done; c++) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=%h expected=%h", 0, 1);
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule